// File: doc/BRIEF.md
# Serial Synthesiser Control Register

This block takes a 27-bit control word for a frequency synthesiser from a three-line serial link (data, serial clock, enable). It presents that word as separate decoded fields: three port output levels, a 17-bit loop divider ratio, a 3-bit reference divider select, a charge-pump current select, a divide-by-two prescaler enable, a test-mode bit and a varactor-drive disable. The serial lines are asynchronous to the system clock. Each line passes through a two-stage synchroniser, and a rising serial clock edge is detected in the system domain. A bit is sampled only while enable is high.

A frame runs from enable rising to enable falling. If exactly 27 serial clock edges arrived in the frame, the word is accepted when enable falls. All fields except the divider ratio update at once. The new ratio waits in a shadow register until the divider signals the end of its cycle with a one-cycle strobe, so the divider never sees a ratio change part-way through a count. A frame with any other number of edges is dropped and raises a one-cycle error flag.

The sequencer has four states:
- IDLE clears the bit count and moves to SHIFT once the synchronised enable is high.
- SHIFT takes one bit per detected edge. When enable drops it moves to ACCEPT if the count is exactly 27, or to DROP otherwise.
- ACCEPT loads the holding registers and the ratio shadow, then returns to IDLE.
- DROP raises the error flag for one cycle, then returns to IDLE.

Top module: `serial_ctrl_reg`

## Requirements
- R1: While reset is asserted and after it is released, all field outputs and the error flag read zero.
- R2: A frame with exactly 27 rising serial clock edges updates the port, reference select, charge-pump, prescaler, test and drive-disable outputs after enable falls. None of these outputs changes at any other time.
- R3: Field layout of the received word, bit 26 being the first bit sent: [26:24] port outputs, [23:7] divider ratio, [6:4] reference select, [3] charge-pump high current, [2] prescaler enable, [1] test mode, [0] varactor drive disable.
- R4: Serial clock and data activity while enable is low has no effect on any output.
- R5: A frame with fewer or more than 27 edges leaves every field output unchanged and raises the error flag for exactly one cycle.
- R6: An accepted ratio is applied to the ratio output only in a cycle with the divider strobe high. The ratio output never changes without that strobe.
- R7: A later accepted word replaces an earlier ratio still waiting in the shadow. A strobe with no pending ratio leaves the ratio output unchanged.
- R8: Bits are taken on rising serial clock edges, most significant bit first. Every output follows a reference model cycle for cycle, including the two-stage synchroniser delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_en_i | input | 1 | Frame enable, asynchronous |
| div_wrap_i | input | 1 | Divider cycle-boundary strobe |
| port_o | output | 3 | Port output levels |
| ratio_o | output | 17 | Divider ratio |
| ref_sel_o | output | 3 | Reference divider select |
| cp_hi_o | output | 1 | Charge-pump high current |
| pre_en_o | output | 1 | Divide-by-two prescaler enable |
| test_o | output | 1 | Test mode |
| drv_off_o | output | 1 | Varactor drive disable |
| word_err_o | output | 1 | One-cycle flag for a dropped frame |

## Verification
The bench builds the block with its default widths: a 3-bit port field, a 17-bit ratio, a 3-bit reference select and two synchroniser stages. With these values the full 27-bit layout is checked, and frames one edge short and one edge long (26 and 28 edges) exercise the exact-count test and the saturating counter. Serial clock edges are spaced several system cycles apart, so the two-stage synchroniser latency, the ACCEPT and DROP states and a divider strobe coinciding with pending or absent updates all show up in the cycle-by-cycle model comparison.

// File: rtl/scr_pkg.sv
package scr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_ACCEPT = 2'd2,
        ST_DROP   = 2'd3
    } scr_state_e;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[CHAIN_W-W-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/scr_shifter.sv
module scr_shifter #(
    parameter int WORD_W = 27,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              clr_i,
    input  logic              take_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

    logic sclk_d;
    logic rise;

    assign rise = sclk_s & ~sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            word_o <= '0;
            cnt_o  <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (clr_i) begin
                cnt_o <= '0;
            end else if (take_i && rise) begin
                word_o <= {word_o[WORD_W-2:0], sdat_s};
                if (cnt_o != CNT_SAT) cnt_o <= cnt_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scr_fsm.sv
module scr_fsm
    import scr_pkg::*;
#(
    parameter int WORD_W = 27,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_s,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             clr_o,
    output logic             take_o,
    output logic             accept_o,
    output logic             drop_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    scr_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (en_s) state_nx = ST_SHIFT;
            ST_SHIFT:  if (!en_s) state_nx = (cnt_i == CNT_FULL) ? ST_ACCEPT : ST_DROP;
            ST_ACCEPT: state_nx = ST_IDLE;
            ST_DROP:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        clr_o    = (state == ST_IDLE);
        take_o   = (state == ST_SHIFT) && en_s;
        accept_o = (state == ST_ACCEPT);
        drop_o   = (state == ST_DROP);
    end
endmodule

// File: rtl/serial_ctrl_reg.sv
module serial_ctrl_reg #(
    parameter int PORT_W      = 3,
    parameter int RATIO_W     = 17,
    parameter int REF_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_data_i,
    input  logic               ser_clk_i,
    input  logic               ser_en_i,
    input  logic               div_wrap_i,
    output logic [PORT_W-1:0]  port_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [REF_W-1:0]   ref_sel_o,
    output logic               cp_hi_o,
    output logic               pre_en_o,
    output logic               test_o,
    output logic               drv_off_o,
    output logic               word_err_o
);
    localparam int WORD_W    = PORT_W + RATIO_W + REF_W + 4;
    localparam int CNT_W     = $clog2(WORD_W + 2);
    localparam int PORT_LSB  = WORD_W - PORT_W;
    localparam int RATIO_LSB = PORT_LSB - RATIO_W;
    localparam int REF_LSB   = RATIO_LSB - REF_W;

    logic [2:0]         sync_q;
    logic               en_s, sclk_s, sdat_s;
    logic [WORD_W-1:0]  word;
    logic [CNT_W-1:0]   cnt;
    logic               clr, take, commit, drop;
    logic [RATIO_W-1:0] ratio_shadow;
    logic               ratio_pend;

    scr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_en_i, ser_clk_i, ser_data_i}),
        .q_o   (sync_q)
    );
    assign {en_s, sclk_s, sdat_s} = sync_q;

    scr_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sclk_s),
        .sdat_s (sdat_s),
        .clr_i  (clr),
        .take_i (take),
        .word_o (word),
        .cnt_o  (cnt)
    );

    scr_fsm #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_s     (en_s),
        .cnt_i    (cnt),
        .clr_o    (clr),
        .take_o   (take),
        .accept_o (commit),
        .drop_o   (drop)
    );

    assign word_err_o = drop;

    // Immediate fields: loaded in the accept cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_o    <= '0;
            ref_sel_o <= '0;
            cp_hi_o   <= 1'b0;
            pre_en_o  <= 1'b0;
            test_o    <= 1'b0;
            drv_off_o <= 1'b0;
        end else if (commit) begin
            port_o    <= word[PORT_LSB +: PORT_W];
            ref_sel_o <= word[REF_LSB +: REF_W];
            cp_hi_o   <= word[3];
            pre_en_o  <= word[2];
            test_o    <= word[1];
            drv_off_o <= word[0];
        end
    end

    // Ratio: shadowed until the divider reports its cycle boundary.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_shadow <= '0;
            ratio_pend   <= 1'b0;
            ratio_o      <= '0;
        end else begin
            if (div_wrap_i && ratio_pend) ratio_o <= ratio_shadow;
            if (commit) begin
                ratio_shadow <= word[RATIO_LSB +: RATIO_W];
                ratio_pend   <= 1'b1;
            end else if (div_wrap_i) begin
                ratio_pend   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/scr_chk.sv
module scr_chk #(
    parameter int PORT_W  = 3,
    parameter int RATIO_W = 17,
    parameter int REF_W   = 3,
    parameter int CNT_W   = 5,
    parameter int WORD_W  = 27
) (
    input logic               clk,
    input logic               rst_n,
    input logic               div_wrap_i,
    input logic [PORT_W-1:0]  port_o,
    input logic [RATIO_W-1:0] ratio_o,
    input logic [REF_W-1:0]   ref_sel_o,
    input logic               cp_hi_o,
    input logic               pre_en_o,
    input logic               test_o,
    input logic               drv_off_o,
    input logic               word_err_o,
    input logic               commit,
    input logic               en_s,
    input logic [CNT_W-1:0]   cnt
);
    p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_err_o |=> !word_err_o);

    p_ratio_needs_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !div_wrap_i |=> $stable(ratio_o));

    p_fields_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(port_o) && $stable(ref_sel_o) && $stable(cp_hi_o)
                     && $stable(pre_en_o) && $stable(test_o) && $stable(drv_off_o)));

    p_accept_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !en_s);

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WORD_W + 1));
endmodule

bind serial_ctrl_reg scr_chk #(
    .PORT_W  (PORT_W),
    .RATIO_W (RATIO_W),
    .REF_W   (REF_W),
    .CNT_W   (CNT_W),
    .WORD_W  (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_wrap_i (div_wrap_i),
    .port_o     (port_o),
    .ratio_o    (ratio_o),
    .ref_sel_o  (ref_sel_o),
    .cp_hi_o    (cp_hi_o),
    .pre_en_o   (pre_en_o),
    .test_o     (test_o),
    .drv_off_o  (drv_off_o),
    .word_err_o (word_err_o),
    .commit     (commit),
    .en_s       (en_s),
    .cnt        (cnt)
);

// File: tb/test_serial_ctrl_reg.sv
module test_serial_ctrl_reg;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_data = 1'b0, ser_clk = 1'b0, ser_en = 1'b0, div_wrap = 1'b0;
    logic [2:0]  port_o, ref_sel_o;
    logic [16:0] ratio_o;
    logic        cp_hi_o, pre_en_o, test_o, drv_off_o, word_err_o;

    int n_tests = 0, n_fail = 0, err_seen = 0, cyc = 0;
    bit cmp_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_ctrl_reg i_serial_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .ser_data_i(ser_data), .ser_clk_i(ser_clk),
        .ser_en_i(ser_en), .div_wrap_i(div_wrap), .port_o(port_o), .ratio_o(ratio_o),
        .ref_sel_o(ref_sel_o), .cp_hi_o(cp_hi_o), .pre_en_o(pre_en_o), .test_o(test_o),
        .drv_off_o(drv_off_o), .word_err_o(word_err_o)
    );

    // Behavioural reference model (R8)
    int          m_state = 0, m_cnt = 0;
    logic [26:0] m_sr = '0;
    logic [2:0]  m_port = '0, m_ref = '0;
    logic [16:0] m_ratio = '0, m_shadow = '0;
    logic        m_cp = 0, m_pre = 0, m_tst = 0, m_drv = 0, m_pend = 0;
    logic        m_ck_prev = 0;
    logic        sync_q[$];
    logic [2:0]  pipe [2];
    logic [2:0]  late;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_sr = '0; m_port = '0; m_ref = '0;
            m_ratio = '0; m_shadow = '0; m_cp = 0; m_pre = 0; m_tst = 0;
            m_drv = 0; m_pend = 0; m_ck_prev = 0;
            pipe[0] = '0; pipe[1] = '0;
        end else begin
            late = pipe[1];   // {en, clk, data} after two flops
            if (div_wrap && m_pend) begin m_ratio = m_shadow; m_pend = 0; end
            case (m_state)
                0: begin m_cnt = 0; if (late[2]) m_state = 1; end
                1: begin
                    if (!late[2]) m_state = (m_cnt == 27) ? 2 : 3;
                    else if (late[1] && !m_ck_prev) begin
                        m_sr = {m_sr[25:0], late[0]};
                        if (m_cnt < 28) m_cnt++;
                    end
                end
                2: begin
                    m_port = m_sr[26:24]; m_shadow = m_sr[23:7]; m_ref = m_sr[6:4];
                    m_cp = m_sr[3]; m_pre = m_sr[2]; m_tst = m_sr[1]; m_drv = m_sr[0];
                    m_pend = 1; m_state = 0;
                end
                default: m_state = 0;
            endcase
            m_ck_prev = late[1];
            pipe[1] = pipe[0];
            pipe[0] = {ser_en, ser_clk, ser_data};
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (word_err_o === 1'b1) err_seen++;
        if (cmp_on)
            check("R8 cycle model",
                  {port_o, ratio_o, ref_sel_o, cp_hi_o, pre_en_o, test_o, drv_off_o, word_err_o},
                  {m_port, m_ratio, m_ref, m_cp, m_pre, m_tst, m_drv, (m_state == 3)});
        if (cyc > WATCHDOG) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [31:0] bits, int n);
        ser_en = 1'b1; wait_n(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i]; wait_n(3);
            ser_clk = 1'b1;     wait_n(3);
            ser_clk = 1'b0;     wait_n(3);
        end
        ser_en = 1'b0; wait_n(8);
    endtask

    task automatic strobe();
        div_wrap = 1'b1; wait_n(1);
        div_wrap = 1'b0; wait_n(3);
    endtask

    function automatic logic [26:0] pack(logic [2:0] p, logic [16:0] r, logic [2:0] f,
                                         logic c, logic e, logic t, logic d);
        return {p, r, f, c, e, t, d};   // R3 layout
    endfunction

    task automatic check_imm(string req, logic [26:0] w);
        check({req, " port"},  64'(port_o),    64'(w[26:24]));
        check({req, " ref"},   64'(ref_sel_o), 64'(w[6:4]));
        check({req, " flags"}, 64'({cp_hi_o, pre_en_o, test_o, drv_off_o}), 64'(w[3:0]));
    endtask

    logic [26:0] wa, wb, wc;

    initial begin
        wa = pack(3'b101, 17'h1A5C3, 3'b110, 1'b1, 1'b0, 1'b1, 1'b0);
        wb = pack(3'b010, 17'h00F0F, 3'b001, 1'b0, 1'b1, 1'b0, 1'b1);
        wc = pack(3'b111, 17'h13579, 3'b011, 1'b1, 1'b1, 1'b0, 1'b0);
        wait_n(2);
        check("R1 reset outputs", 64'({port_o, ratio_o, ref_sel_o, cp_hi_o, pre_en_o, test_o,
              drv_off_o, word_err_o}), 64'd0);
        rst_n = 1'b1; wait_n(2);
        cmp_on = 1;
        check("R1 after release", 64'({port_o, ratio_o, word_err_o}), 64'd0);

        // R2 / R3 / R8: full frame, immediate fields, ratio held (R6)
        send(32'(wa), 27);
        check_imm("R2 R3 word A", wa);
        check("R6 ratio held before strobe", 64'(ratio_o), 64'd0);
        strobe();
        check("R6 ratio after strobe", 64'(ratio_o), 64'(wa[23:7]));

        // R4: activity while enable low
        err_seen = 0;
        for (int k = 0; k < 10; k++) begin
            ser_data = k[0]; wait_n(2); ser_clk = 1'b1; wait_n(2); ser_clk = 1'b0; wait_n(2);
        end
        wait_n(6);
        check_imm("R4 enable low", wa);
        check("R4 no error", 64'(err_seen), 64'd0);

        // R5: short and long frames
        err_seen = 0;
        send(32'(wb[26:1]), 26);
        check("R5 short error pulse", 64'(err_seen), 64'd1);
        check_imm("R5 short discarded", wa);
        err_seen = 0;
        send({wb, 1'b1}, 28);
        check("R5 long error pulse", 64'(err_seen), 64'd1);
        check_imm("R5 long discarded", wa);
        strobe();
        check("R5 ratio untouched", 64'(ratio_o), 64'(wa[23:7]));

        // R7: newer word overwrites pending shadow
        send(32'(wb), 27);
        check_imm("R2 word B", wb);
        send(32'(wc), 27);
        check_imm("R2 word C", wc);
        check("R6 ratio still A", 64'(ratio_o), 64'(wa[23:7]));
        strobe();
        check("R7 latest ratio applied", 64'(ratio_o), 64'(wc[23:7]));
        send(32'(wb), 27);
        strobe();
        check("R7 ratio B", 64'(ratio_o), 64'(wb[23:7]));
        strobe();
        check("R7 strobe with nothing pending", 64'(ratio_o), 64'(wb[23:7]));

        wait_n(4);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule